// File: doc/BRIEF.md
# Pulse frequency modulator

This block is a timer peripheral that drives one square-wave pin. The period and the pulse width of the wave are set separately. A 16-bit period down-counter and an 8-bit pulse-width down-counter start together at the beginning of every period. The pulse-width counter stops when it reaches zero and raises a zero flag. The flag stays high until the period counter reaches zero. At that point both counters reload from their reload registers and the next period begins. The pin carries the zero flag, either as it is or complemented. In a typical use the pin drives an external charge pump, but that circuit lies outside the block.

The counters do not run on a clock of their own. They advance on one of several single-cycle tick inputs, and a static select input chooses which tick source is used. When the block is disabled it sits in standby: both counters follow their reload registers and the zero flag stays low. Software writes new reload values through simple write strobes. A new value only takes effect when the period counter next reloads.

The control is a three-state machine:
- STANDBY: the block is disabled.
- PULSE_LOW: the width counter is still running, so the flag is low.
- PULSE_HIGH: the width counter is parked at zero, so the flag is high.

The transitions are:
- wake: STANDBY to PULSE_LOW when the enable input is set.
- width_done: PULSE_LOW to PULSE_HIGH on a tick where the width counter is already zero and the period counter is not.
- period_end: PULSE_HIGH to PULSE_LOW on a tick where the period counter is zero.
- sleep: any state to STANDBY when the enable input is clear.

Top module: `pulse_freq_mod`

## Requirements
- R1: After asynchronous reset the block is in STANDBY, both reload registers hold zero, and `pfm_o` equals `invert_i`.
- R2: While `enable_i` is low, and in the cycle after it falls, `pfm_o` equals `invert_i` whatever the tick inputs do, and both counters are loaded from the reload registers on every clock.
- R3: The counters advance only on clocks where `tick_src_i[clk_sel_i]` is high. A clock where only a non-selected source ticks leaves the counters and the output unchanged.
- R4: With period reload value P, one period lasts P+1 ticks, counting the reload tick. On the reload tick both counters take their reload values.
- R5: With width reload value W and W < P, the flag before inversion is low for the first W+1 ticks of each period and high for the remaining P-W ticks.
- R6: When W >= P, the flag before inversion stays low for the whole period.
- R7: When `invert_i` is 1, `pfm_o` is the complement of the flag. When it is 0, `pfm_o` equals the flag.
- R8: A write to a reload register is used only from the next period-counter reload, or from standby. The period in progress keeps its old values.
- R9: After `enable_i` rises, the first period begins at the first selected tick that follows the clock on which the block leaves STANDBY.
- R10: Once the width counter reaches zero it holds there, and the flag stays high until the period reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Module enable; low means standby |
| clk_sel_i | input | SEL_W (1) | Index of the tick source that drives counting |
| tick_src_i | input | N_SRC (2) | Single-cycle count-enable pulses, one per source |
| period_wr_i | input | 1 | Write strobe for the period reload register |
| period_val_i | input | PER_W (16) | Value for the period reload register |
| width_wr_i | input | 1 | Write strobe for the width reload register |
| width_val_i | input | WID_W (8) | Value for the width reload register |
| invert_i | input | 1 | Output polarity; 1 complements the flag |
| pfm_o | output | 1 | Modulated output |

## Verification
The bound checker watches local rules on every clock:
- standby silences the pin;
- the counters and the flag stay frozen when the selected tick is absent;
- the period counter steps down by one per tick;
- both counters take the reload registers on the reload tick;
- a raised flag implies a parked width counter, and the flag holds until the reload.

Some behaviours span whole periods and only the bench scenarios show them. These are the exact low and high durations for several P and W pairs, the W >= P constant-low case, deferral of a mid-period write to the next reload, the start of the period after enable, and the source selection when only a non-selected source ticks.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

    typedef enum logic [1:0] {
        PFM_STANDBY    = 2'd0,
        PFM_PULSE_LOW  = 2'd1,
        PFM_PULSE_HIGH = 2'd2
    } pfm_state_e;

endpackage

// File: rtl/pfm_tick_mux.sv
module pfm_tick_mux #(
    parameter int N_SRC = 2,
    parameter int SEL_W = 1
) (
    input  logic [N_SRC-1:0] src_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    generate
        if (N_SRC == 1) begin : g_single
            logic unused_sel;
            assign unused_sel = ^sel_i;
            assign tick_o     = src_i[0];
        end else begin : g_multi
            always_comb begin
                tick_o = 1'b0;
                for (int i = 0; i < N_SRC; i++) begin
                    if (int'(sel_i) == i) begin
                        tick_o = src_i[i];
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pfm_reload_reg.sv
module pfm_reload_reg #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_o <= '0;
        end else if (wr_i) begin
            q_o <= val_i;
        end
    end

endmodule

// File: rtl/pfm_down_cnt.sv
module pfm_down_cnt #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic         dec_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o
);

    // A load has priority over a step; the count parks at zero.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_o <= '0;
        end else if (load_i) begin
            cnt_o <= load_val_i;
        end else if (dec_i && (cnt_o != '0)) begin
            cnt_o <= cnt_o - W'(1);
        end
    end

endmodule

// File: rtl/pfm_fsm.sv
module pfm_fsm
    import pfm_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       enable_i,
    input  logic       tick_i,
    input  logic       per_zero_i,
    input  logic       wid_zero_i,
    output pfm_state_e state_o,
    output logic       run_o,
    output logic       flag_o
);

    pfm_state_e state_q;
    pfm_state_e state_d;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= PFM_STANDBY;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: wake, width_done, period_end, sleep
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PFM_STANDBY: begin
                if (enable_i) begin
                    state_d = PFM_PULSE_LOW;
                end
            end
            PFM_PULSE_LOW: begin
                if (!enable_i) begin
                    state_d = PFM_STANDBY;
                end else if (tick_i && !per_zero_i && wid_zero_i) begin
                    state_d = PFM_PULSE_HIGH;
                end
            end
            PFM_PULSE_HIGH: begin
                if (!enable_i) begin
                    state_d = PFM_STANDBY;
                end else if (tick_i && per_zero_i) begin
                    state_d = PFM_PULSE_LOW;
                end
            end
            default: state_d = PFM_STANDBY;
        endcase
    end

    // Outputs
    always_comb begin
        run_o  = 1'b0;
        flag_o = 1'b0;
        unique case (state_q)
            PFM_STANDBY: begin
                run_o  = 1'b0;
                flag_o = 1'b0;
            end
            PFM_PULSE_LOW: begin
                run_o  = enable_i;
                flag_o = 1'b0;
            end
            PFM_PULSE_HIGH: begin
                run_o  = enable_i;
                flag_o = 1'b1;
            end
            default: begin
                run_o  = 1'b0;
                flag_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/pulse_freq_mod.sv
module pulse_freq_mod
    import pfm_pkg::*;
#(
    parameter int PER_W = 16,
    parameter int WID_W = 8,
    parameter int N_SRC = 2,
    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic [SEL_W-1:0] clk_sel_i,
    input  logic [N_SRC-1:0] tick_src_i,
    input  logic             period_wr_i,
    input  logic [PER_W-1:0] period_val_i,
    input  logic             width_wr_i,
    input  logic [WID_W-1:0] width_val_i,
    input  logic             invert_i,
    output logic             pfm_o
);

    logic             tick_sel;
    logic             run_en;
    logic             pulse_flag;
    logic             per_zero;
    logic             wid_zero;
    logic             cnt_load;
    logic             cnt_dec;
    logic [PER_W-1:0] per_rl;
    logic [WID_W-1:0] wid_rl;
    logic [PER_W-1:0] per_cnt;
    logic [WID_W-1:0] wid_cnt;
    pfm_state_e       state;

    pfm_tick_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_tick (
        .src_i  (tick_src_i),
        .sel_i  (clk_sel_i),
        .tick_o (tick_sel)
    );

    pfm_reload_reg #(.W(PER_W)) u_per_rl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (period_wr_i),
        .val_i  (period_val_i),
        .q_o    (per_rl)
    );

    pfm_reload_reg #(.W(WID_W)) u_wid_rl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (width_wr_i),
        .val_i  (width_val_i),
        .q_o    (wid_rl)
    );

    assign per_zero = (per_cnt == '0);
    assign wid_zero = (wid_cnt == '0);

    // Outside a run the counters track the reload registers; inside a
    // run they reload together when the period count is spent.
    assign cnt_load = !run_en || (tick_sel && per_zero);
    assign cnt_dec  = run_en && tick_sel && !per_zero;

    pfm_down_cnt #(.W(PER_W)) u_per_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (cnt_load),
        .dec_i      (cnt_dec),
        .load_val_i (per_rl),
        .cnt_o      (per_cnt)
    );

    pfm_down_cnt #(.W(WID_W)) u_wid_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (cnt_load),
        .dec_i      (cnt_dec),
        .load_val_i (wid_rl),
        .cnt_o      (wid_cnt)
    );

    pfm_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enable_i   (enable_i),
        .tick_i     (tick_sel),
        .per_zero_i (per_zero),
        .wid_zero_i (wid_zero),
        .state_o    (state),
        .run_o      (run_en),
        .flag_o     (pulse_flag)
    );

    assign pfm_o = pulse_flag ^ invert_i;

    logic unused_state;
    assign unused_state = ^state;

endmodule

// File: rtl/pulse_freq_mod_chk.sv
module pulse_freq_mod_chk #(
    parameter int PER_W = 16,
    parameter int WID_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             enable_i,
    input logic             invert_i,
    input logic             pfm_o,
    input logic             tick_sel,
    input logic             run_en,
    input logic             pulse_flag,
    input logic [PER_W-1:0] per_cnt,
    input logic [WID_W-1:0] wid_cnt,
    input logic [PER_W-1:0] per_rl,
    input logic [WID_W-1:0] wid_rl
);

    p_standby_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (pfm_o == invert_i));

    p_standby_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (per_cnt == $past(per_rl)) && (wid_cnt == $past(wid_rl)));

    p_no_tick_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_en && !tick_sel) |=> $stable(per_cnt) && $stable(wid_cnt) && $stable(pulse_flag));

    p_period_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_en && tick_sel && (per_cnt != '0)) |=> (per_cnt == $past(per_cnt) - PER_W'(1)));

    p_reload_both_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_en && tick_sel && (per_cnt == '0)) |=>
            (per_cnt == $past(per_rl)) && (wid_cnt == $past(wid_rl)) && !pulse_flag);

    p_high_parked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_flag |-> (wid_cnt == '0));

    p_high_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pulse_flag && enable_i && !(tick_sel && (per_cnt == '0))) |=> pulse_flag);

endmodule

bind pulse_freq_mod pulse_freq_mod_chk #(.PER_W(PER_W), .WID_W(WID_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .invert_i   (invert_i),
    .pfm_o      (pfm_o),
    .tick_sel   (tick_sel),
    .run_en     (run_en),
    .pulse_flag (pulse_flag),
    .per_cnt    (per_cnt),
    .wid_cnt    (wid_cnt),
    .per_rl     (per_rl),
    .wid_rl     (wid_rl)
);

// File: tb/pulse_freq_mod_tb.sv
module pulse_freq_mod_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [0:0]  sel = '0;
    logic [1:0]  src = '0;
    logic        pwr = 1'b0;
    logic [15:0] pval = '0;
    logic        wwr = 1'b0;
    logic [7:0]  wval = '0;
    logic        inv = 1'b0;
    logic        pfm;

    always #2 clk = ~clk;

    pulse_freq_mod u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .enable_i     (enable),
        .clk_sel_i    (sel),
        .tick_src_i   (src),
        .period_wr_i  (pwr),
        .period_val_i (pval),
        .width_wr_i   (wwr),
        .width_val_i  (wval),
        .invert_i     (inv),
        .pfm_o        (pfm)
    );

    typedef struct {
        bit    exp;
        string tag;
    } item_t;

    item_t q[$];
    int    n_tests = 0;
    int    n_fail = 0;
    bit    done = 0;

    // Reference model state, derived from the requirements
    int k = 0;
    int act_p = 0, act_w = 0, pend_p = 0, pend_w = 0;
    bit run_prev = 0;

    task automatic step(input bit en, input bit s, input bit [1:0] ticks, input bit iv,
                        input bit wp, input int pv, input bit ww, input int wv,
                        input string tag);
        item_t it;
        @(negedge clk);
        enable = en; sel = s; src = ticks; inv = iv;
        pwr = wp; pval = 16'(pv); wwr = ww; wval = 8'(wv);
        if (!(en && run_prev)) begin
            k = 0; act_p = pend_p; act_w = pend_w;
        end else if (ticks[s]) begin
            if (k == act_p) begin
                k = 0; act_p = pend_p; act_w = pend_w;
            end else begin
                k = k + 1;
            end
        end
        if (wp) pend_p = pv;
        if (ww) pend_w = wv;
        run_prev = en;
        it.exp = ((en && (k >= act_w + 1) && (k <= act_p)) ? 1'b1 : 1'b0) ^ iv;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic run_n(input int n, input bit en, input bit s, input bit [1:0] ticks,
                         input bit iv, input string tag);
        for (int i = 0; i < n; i++) step(en, s, ticks, iv, 0, 0, 0, 0, tag);
    endtask

    // Monitor: pop one expected item per clock, after the edge settles
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_tests++;
                if (pfm !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: pfm_o=%0b expected %0b at %0t", it.tag, pfm, it.exp, $time);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, polarity straight through
        n_tests++;
        if (pfm !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: pfm_o=%0b expected 0 during reset", pfm);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_tests++;
        if (pfm !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: pfm_o=%0b expected 0 after reset", pfm);
        end
        // R1: zero reload values give a one-tick period, always low
        step(1, 0, 2'b01, 0, 0, 0, 0, 0, "R1");
        run_n(4, 1, 0, 2'b01, 0, "R1");
        // R2: standby with ticks present, both polarities
        run_n(3, 0, 0, 2'b11, 0, "R2");
        run_n(3, 0, 0, 2'b11, 1, "R2");
        // R8: load values in standby
        step(0, 0, 2'b00, 0, 1, 5, 1, 2, "R8");
        // R9 / R4 / R5: enable, tick every clock
        step(1, 0, 2'b01, 0, 0, 0, 0, 0, "R9");
        run_n(20, 1, 0, 2'b01, 0, "R5");
        // R3: only the non-selected source ticks
        run_n(6, 1, 0, 2'b10, 0, "R3");
        run_n(12, 1, 1, 2'b10, 0, "R3");
        for (int i = 0; i < 16; i++) step(1, 0, (i % 2) ? 2'b01 : 2'b10, 0, 0, 0, 0, 0, "R3");
        // R7: inverted polarity
        run_n(14, 1, 0, 2'b01, 1, "R7");
        // R8: mid-period write, then W >= P (R6)
        run_n(2, 1, 0, 2'b01, 0, "R8");
        step(1, 0, 2'b01, 0, 1, 3, 1, 7, "R8");
        run_n(6, 1, 0, 2'b01, 0, "R8");
        run_n(12, 1, 0, 2'b01, 0, "R6");
        step(1, 0, 2'b01, 0, 0, 0, 1, 3, "R6");
        run_n(14, 1, 0, 2'b01, 0, "R6");
        // R10: zero width, flag held high to the reload
        step(1, 0, 2'b01, 0, 1, 6, 1, 0, "R10");
        run_n(24, 1, 0, 2'b01, 0, "R10");
        // R2 / R9: disable mid-period, then restart
        run_n(3, 1, 0, 2'b01, 0, "R2");
        run_n(4, 0, 0, 2'b01, 0, "R2");
        step(1, 0, 2'b01, 0, 0, 0, 0, 0, "R9");
        run_n(12, 1, 0, 2'b01, 0, "R9");
        // R4 / R5: longer period, sparse ticks on source 1
        step(1, 1, 2'b10, 0, 1, 300, 1, 100, "R4");
        for (int i = 0; i < 1500; i++) step(1, 1, (i % 2) ? 2'b10 : 2'b00, 0, 0, 0, 0, 0, "R4");
        run_n(1, 0, 0, 2'b00, 0, "R2");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule